// File: doc/BRIEF.md
# Sliced Global/Private Register File

This block is the register file for a wide-issue core that is cut into instruction slices. Every slice presents two 7-bit read specifiers and one 7-bit write specifier. The specifier is decoded by the slice that issues it. Low specifier values reach a bank of global registers that all slices share. The values just above the global range reach a bank of private registers that belongs only to the issuing slice. Because of this, the same specifier value can name a different physical register in each slice.

Each slice holds its own copy of the global bank, so its reads stay local to that slice. Every global write is broadcast to all of the copies, which keeps them identical. All of the writes in one instruction packet commit together on the clock edge on which the packet strobe is high. Reads are combinational from the stored state. A read made in the same cycle as a write therefore returns the value from before the packet.

Two error outputs exist. One flags a specifier that falls outside the configured register range. The other flags two slices that target the same global register in one packet. The legal configurations are fixed by the parameters. The global count is a nonzero multiple of 32. The private count is a multiple of 32 and is at least 32 in this build. The global count plus the private count is at most 128.

Top module: `gfRegFile`

## Requirements
- R1: After reset, every register reads as zero through both read ports of every slice.
- R2: A specifier below NUM_GLOBAL selects global register `spec`. A value written to it by any slice reads back identically from every slice on the cycle after the commit.
- R3: A specifier from NUM_GLOBAL to NUM_GLOBAL+NUM_PRIV-1 selects private register `spec-NUM_GLOBAL` of the issuing slice. A write to it changes only that slice's register, so other slices using the same specifier still see their own contents.
- R4: A specifier of NUM_GLOBAL+NUM_PRIV or above sets `specErr[s]` for the slice that uses it, in the same cycle. A write with such a specifier changes no register. A read with such a specifier returns zero.
- R5: Registers change only on a rising edge where `pktValid` is 1. When `pktValid` is 0, `wrEn` has no effect.
- R6: All enabled writes of one packet, from any mix of slices, commit on the same single edge.
- R7: When two or more slices write the same global register in one packet, `collideErr` is 1 in that cycle and the write from the lowest-numbered slice is the one stored.
- R8: A read issued in the cycle of a packet that writes the same register returns the value from before the packet. The new value appears after the edge.
- R9: The two read ports of a slice decode and return data independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pktValid | input | 1 | Commit strobe for the current packet's writes |
| wrEn | input | NUM_SLICES | Per-slice write enable |
| wrSpec | input | NUM_SLICES*7 | Per-slice write specifier; slice s uses bits [7s+6:7s] |
| wrData | input | NUM_SLICES*DATA_W | Per-slice write data |
| rdSpecA | input | NUM_SLICES*7 | Per-slice specifier for read port A |
| rdSpecB | input | NUM_SLICES*7 | Per-slice specifier for read port B |
| rdDataA | output | NUM_SLICES*DATA_W | Per-slice data from read port A |
| rdDataB | output | NUM_SLICES*DATA_W | Per-slice data from read port B |
| specErr | output | NUM_SLICES | Out-of-range specifier used by slice s on a read, or on a committing write |
| collideErr | output | 1 | Two slices target one global register in the current packet |

## Verification
The hardest situation to reach is a packet where several slices hit the same global register while another slice writes a different global register. In that packet the lowest slice must win, and the losing writes must be dropped from every copy. The non-colliding write must still land. The bench builds this packet directly. It then sweeps every specifier through every slice, so that any copy that drifted, or any loser that leaked through, shows up as a mismatch against the arithmetic model. Same-specifier private writes from all slices at once, and out-of-range specifiers at the exact range boundary, are handled the same way: each such packet is followed by a full sweep.

// File: rtl/gfRfPkg.sv
package gfRfPkg;
  localparam int SPEC_W = 7;

  typedef struct packed {
    logic              isGlob;
    logic              isPriv;
    logic [SPEC_W-1:0] idx;
  } regSel_t;

  typedef struct packed {
    logic              globWe;
    logic              privWe;
    logic [SPEC_W-1:0] idx;
  } wrStrobe_t;
endpackage

// File: rtl/gfRfCtrl.sv
module gfRfCtrl
  import gfRfPkg::*;
#(
  parameter int NUM_SLICES = 4,
  parameter int NUM_GLOBAL = 32,
  parameter int NUM_PRIV   = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pktValid,
  input  logic [NUM_SLICES-1:0]        wrEn,
  input  logic [NUM_SLICES*SPEC_W-1:0] wrSpec,
  input  logic [NUM_SLICES*SPEC_W-1:0] rdSpecA,
  input  logic [NUM_SLICES*SPEC_W-1:0] rdSpecB,
  output wrStrobe_t                    wrStb [NUM_SLICES],
  output regSel_t                      selA  [NUM_SLICES],
  output regSel_t                      selB  [NUM_SLICES],
  output logic [NUM_SLICES-1:0]        specErr,
  output logic                         collideErr
);
  localparam int LIMIT = NUM_GLOBAL + NUM_PRIV;

  function automatic regSel_t decodeSpec(input logic [SPEC_W-1:0] spec);
    regSel_t r;
    r = '0;
    if (int'(spec) < NUM_GLOBAL) begin
      r.isGlob = 1'b1;
      r.idx    = spec;
    end else if (int'(spec) < LIMIT) begin
      r.isPriv = 1'b1;
      r.idx    = spec - SPEC_W'(NUM_GLOBAL);
    end
    return r;
  endfunction

  regSel_t                decW [NUM_SLICES];
  logic [NUM_SLICES-1:0]  globReq;
  logic [NUM_SLICES-1:0]  loser;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_dec
    assign decW[s]    = decodeSpec(wrSpec[s*SPEC_W +: SPEC_W]);
    assign selA[s]    = decodeSpec(rdSpecA[s*SPEC_W +: SPEC_W]);
    assign selB[s]    = decodeSpec(rdSpecB[s*SPEC_W +: SPEC_W]);
    assign globReq[s] = pktValid & wrEn[s] & decW[s].isGlob;

    assign wrStb[s].globWe = globReq[s] & ~loser[s];
    assign wrStb[s].privWe = pktValid & wrEn[s] & decW[s].isPriv;
    assign wrStb[s].idx    = decW[s].idx;

    assign specErr[s] = ~(selA[s].isGlob | selA[s].isPriv)
                      | ~(selB[s].isGlob | selB[s].isPriv)
                      | (pktValid & wrEn[s] & ~(decW[s].isGlob | decW[s].isPriv));

    // R4: an out-of-range write specifier never produces a strobe
    p_err_blocks_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wrStb[s].globWe || wrStb[s].privWe) |-> (int'(wrSpec[s*SPEC_W +: SPEC_W]) < LIMIT));

    // R5: no strobe leaves the control without the packet strobe
    p_idle_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !pktValid |-> !(wrStb[s].globWe || wrStb[s].privWe));
  end

  // Lower slice index wins a global collision
  always_comb begin
    for (int s = 0; s < NUM_SLICES; s++) begin
      loser[s] = 1'b0;
      for (int t = 0; t < s; t++) begin
        if (globReq[t] && globReq[s] && (decW[t].idx == decW[s].idx)) loser[s] = 1'b1;
      end
    end
  end

  assign collideErr = |loser;

  // R7: at most one slice drives any one global register per packet
  for (genvar a = 0; a < NUM_SLICES; a++) begin : g_pa
    for (genvar b = a + 1; b < NUM_SLICES; b++) begin : g_pb
      p_one_winner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wrStb[a].globWe && wrStb[b].globWe && (wrStb[a].idx == wrStb[b].idx)));
    end
  end
endmodule

// File: rtl/gfRfData.sv
module gfRfData
  import gfRfPkg::*;
#(
  parameter int NUM_SLICES = 4,
  parameter int NUM_GLOBAL = 32,
  parameter int NUM_PRIV   = 32,
  parameter int DATA_W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  wrStrobe_t                    wrStb [NUM_SLICES],
  input  logic [NUM_SLICES*DATA_W-1:0] wrData,
  input  regSel_t                      selA  [NUM_SLICES],
  input  regSel_t                      selB  [NUM_SLICES],
  output logic [NUM_SLICES*DATA_W-1:0] rdDataA,
  output logic [NUM_SLICES*DATA_W-1:0] rdDataB
);
  localparam int GI_W = (NUM_GLOBAL > 1) ? $clog2(NUM_GLOBAL) : 1;
  localparam int PI_W = (NUM_PRIV > 1)   ? $clog2(NUM_PRIV)   : 1;

  logic [NUM_GLOBAL-1:0][DATA_W-1:0] globCopy [NUM_SLICES];
  logic [NUM_PRIV-1:0][DATA_W-1:0]   privBank [NUM_SLICES];
  logic                              anyWe;

  always_comb begin
    anyWe = 1'b0;
    for (int s = 0; s < NUM_SLICES; s++) anyWe = anyWe | wrStb[s].globWe | wrStb[s].privWe;
  end

  for (genvar c = 0; c < NUM_SLICES; c++) begin : g_slice
    // Global copy of slice c receives every slice's broadcast write
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        globCopy[c] <= '0;
      end else begin
        for (int s = 0; s < NUM_SLICES; s++) begin
          if (wrStb[s].globWe)
            globCopy[c][wrStb[s].idx[GI_W-1:0]] <= wrData[s*DATA_W +: DATA_W];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        privBank[c] <= '0;
      end else if (wrStb[c].privWe) begin
        privBank[c][wrStb[c].idx[PI_W-1:0]] <= wrData[c*DATA_W +: DATA_W];
      end
    end

    always_comb begin
      if (selA[c].isGlob)      rdDataA[c*DATA_W +: DATA_W] = globCopy[c][selA[c].idx[GI_W-1:0]];
      else if (selA[c].isPriv) rdDataA[c*DATA_W +: DATA_W] = privBank[c][selA[c].idx[PI_W-1:0]];
      else                     rdDataA[c*DATA_W +: DATA_W] = '0;
    end

    always_comb begin
      if (selB[c].isGlob)      rdDataB[c*DATA_W +: DATA_W] = globCopy[c][selB[c].idx[GI_W-1:0]];
      else if (selB[c].isPriv) rdDataB[c*DATA_W +: DATA_W] = privBank[c][selB[c].idx[PI_W-1:0]];
      else                     rdDataB[c*DATA_W +: DATA_W] = '0;
    end

    // R5: without any strobe the stored state holds
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !anyWe |=> ($stable(globCopy[c]) && $stable(privBank[c])));

    if (c > 0) begin : g_cmp
      // R2: every replicated global copy matches the first one
      p_copies_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        globCopy[c] == globCopy[0]);
    end
  end
endmodule

// File: rtl/gfRegFile.sv
module gfRegFile
  import gfRfPkg::*;
#(
  parameter int NUM_SLICES = 4,
  parameter int NUM_GLOBAL = 32,
  parameter int NUM_PRIV   = 32,
  parameter int DATA_W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pktValid,
  input  logic [NUM_SLICES-1:0]        wrEn,
  input  logic [NUM_SLICES*7-1:0]      wrSpec,
  input  logic [NUM_SLICES*DATA_W-1:0] wrData,
  input  logic [NUM_SLICES*7-1:0]      rdSpecA,
  input  logic [NUM_SLICES*7-1:0]      rdSpecB,
  output logic [NUM_SLICES*DATA_W-1:0] rdDataA,
  output logic [NUM_SLICES*DATA_W-1:0] rdDataB,
  output logic [NUM_SLICES-1:0]        specErr,
  output logic                         collideErr
);
  wrStrobe_t wrStb [NUM_SLICES];
  regSel_t   selA  [NUM_SLICES];
  regSel_t   selB  [NUM_SLICES];

  gfRfCtrl #(
    .NUM_SLICES(NUM_SLICES), .NUM_GLOBAL(NUM_GLOBAL), .NUM_PRIV(NUM_PRIV)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pktValid(pktValid), .wrEn(wrEn), .wrSpec(wrSpec),
    .rdSpecA(rdSpecA), .rdSpecB(rdSpecB), .wrStb(wrStb), .selA(selA), .selB(selB),
    .specErr(specErr), .collideErr(collideErr)
  );

  gfRfData #(
    .NUM_SLICES(NUM_SLICES), .NUM_GLOBAL(NUM_GLOBAL), .NUM_PRIV(NUM_PRIV), .DATA_W(DATA_W)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .wrStb(wrStb), .wrData(wrData), .selA(selA), .selB(selB),
    .rdDataA(rdDataA), .rdDataB(rdDataB)
  );
endmodule

// File: tb/gfRegFile_tb.sv
module gfRegFile_tb;
  localparam int S = 4;
  localparam int G = 32;
  localparam int P = 32;
  localparam int W = 32;
  localparam int LIM = G + P;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pktValid = 1'b0;
  logic [S-1:0]     wrEn = '0;
  logic [S*7-1:0]   wrSpec = '0;
  logic [S*W-1:0]   wrData = '0;
  logic [S*7-1:0]   rdSpecA = '0;
  logic [S*7-1:0]   rdSpecB = '0;
  logic [S*W-1:0]   rdDataA;
  logic [S*W-1:0]   rdDataB;
  logic [S-1:0]     specErr;
  logic             collideErr;

  logic [W-1:0] mG [G];
  logic [W-1:0] mP [S][P];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gfRegFile #(.NUM_SLICES(S), .NUM_GLOBAL(G), .NUM_PRIV(P), .DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pktValid(pktValid), .wrEn(wrEn), .wrSpec(wrSpec),
    .wrData(wrData), .rdSpecA(rdSpecA), .rdSpecB(rdSpecB), .rdDataA(rdDataA),
    .rdDataB(rdDataB), .specErr(specErr), .collideErr(collideErr)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expOf(input int s, input int sp);
    if (sp < G) return mG[sp];
    if (sp < LIM) return mP[s][sp-G];
    return '0;
  endfunction

  function automatic logic [W-1:0] gVal(input int g);
    return 32'hA500_0000 + 32'(g) * 32'h0001_0101;
  endfunction

  function automatic logic [W-1:0] pVal(input int s, input int i);
    return 32'h3C00_0000 + 32'(s) * 32'h0010_0000 + 32'(i) * 32'h0000_0203;
  endfunction

  // Full sweep, port B offset from port A (R9)
  task automatic sweep(input string req);
    for (int sp = 0; sp < LIM; sp++) begin
      for (int s = 0; s < S; s++) begin
        rdSpecA[s*7 +: 7] = 7'(sp);
        rdSpecB[s*7 +: 7] = 7'((sp + 5) % LIM);
      end
      #1;
      for (int s = 0; s < S; s++) begin
        chk({req, "/portA"}, rdDataA[s*W +: W], expOf(s, sp));
        chk({req, "/R9 portB"}, rdDataB[s*W +: W], expOf(s, (sp + 5) % LIM));
      end
    end
  endtask

  task automatic setWr(input int s, input int sp, input logic [W-1:0] d);
    wrEn[s] = 1'b1;
    wrSpec[s*7 +: 7] = 7'(sp);
    wrData[s*W +: W] = d;
  endtask

  task automatic commit();
    @(posedge clk);
    @(negedge clk);
    pktValid = 1'b0;
    wrEn = '0;
  endtask

  initial begin
    for (int g = 0; g < G; g++) mG[g] = '0;
    for (int s = 0; s < S; s++) for (int i = 0; i < P; i++) mP[s][i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    sweep("R1 reset");
    chk("R1 specErr", W'(specErr), '0);
    chk("R1 collideErr", W'(collideErr), '0);

    // R2/R6: global sweep, four slices writing four registers per packet
    for (int k = 0; k < G / S; k++) begin
      @(negedge clk);
      pktValid = 1'b1;
      for (int s = 0; s < S; s++) setWr(s, k * S + s, gVal(k * S + s));
      #1;
      chk("R7 no collision", W'(collideErr), '0);
      commit();
      for (int s = 0; s < S; s++) mG[k * S + s] = gVal(k * S + s);
    end
    sweep("R2 R6 global");

    // R3: all slices write the same private specifier at once
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      pktValid = 1'b1;
      for (int s = 0; s < S; s++) setWr(s, G + i, pVal(s, i));
      commit();
      for (int s = 0; s < S; s++) mP[s][i] = pVal(s, i);
    end
    sweep("R3 private");

    // R5: write enables without the packet strobe
    @(negedge clk);
    for (int s = 0; s < S; s++) setWr(s, s * 9, 32'hDEAD_BEEF);
    @(posedge clk);
    @(negedge clk);
    wrEn = '0;
    sweep("R5 no strobe");

    // R4: out-of-range write at the boundary and beyond
    for (int s = 0; s < S; s++) begin
      rdSpecA[s*7 +: 7] = 7'(LIM - 1);
      rdSpecB[s*7 +: 7] = 7'(0);
    end
    @(negedge clk);
    pktValid = 1'b1;
    setWr(1, LIM, 32'h1111_1111);
    setWr(3, 127, 32'h2222_2222);
    #1;
    chk("R4 write specErr", W'(specErr), W'(4'b1010));
    commit();
    sweep("R4 suppressed");
    rdSpecA[2*7 +: 7] = 7'(100);
    rdSpecA[0*7 +: 7] = 7'(LIM - 1);
    rdSpecB[0*7 +: 7] = 7'(0);
    rdSpecB[2*7 +: 7] = 7'(0);
    #1;
    chk("R4 read zero", rdDataA[2*W +: W], '0);
    chk("R4 read specErr", W'(specErr[2]), 32'd1);
    chk("R4 last legal no err", W'(specErr[0]), '0);

    // R7: slices 1..3 collide on global 9, slice 0 writes global 10
    @(negedge clk);
    pktValid = 1'b1;
    setWr(0, 10, 32'h0A0A_0000);
    setWr(1, 9, 32'h0901_0001);
    setWr(2, 9, 32'h0902_0002);
    setWr(3, 9, 32'h0903_0003);
    #1;
    chk("R7 collideErr", W'(collideErr), 32'd1);
    commit();
    mG[10] = 32'h0A0A_0000;
    mG[9]  = 32'h0901_0001;
    sweep("R7 lowest wins");

    // R8: same-cycle read sees old data, new data after the edge
    for (int s = 0; s < S; s++) begin
      rdSpecA[s*7 +: 7] = 7'(3);
      rdSpecB[s*7 +: 7] = 7'(G + 4);
    end
    @(negedge clk);
    pktValid = 1'b1;
    setWr(0, 3, 32'h7777_0003);
    setWr(2, G + 4, 32'h8888_0004);
    #1;
    for (int s = 0; s < S; s++) begin
      chk("R8 old global", rdDataA[s*W +: W], mG[3]);
      chk("R8 old private", rdDataB[s*W +: W], mP[s][4]);
    end
    @(posedge clk);
    #1;
    mG[3] = 32'h7777_0003;
    mP[2][4] = 32'h8888_0004;
    for (int s = 0; s < S; s++) begin
      chk("R8 R2 new global", rdDataA[s*W +: W], mG[3]);
      chk("R8 R3 new private", rdDataB[s*W +: W], mP[s][4]);
    end
    @(negedge clk);
    pktValid = 1'b0;
    wrEn = '0;
    sweep("R8 final");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  end
endmodule